// File: doc/BRIEF.md
# Input Change Interrupt Detector

This block sits behind a general-purpose bidirectional port. It keeps a captured copy of the port's input levels, which is the input port register, and compares the live pin levels against that copy. If any pin set as an input differs from its captured value, the block raises an interrupt. The interrupt is active low and open drain. The block models it as a pull-down enable, so it only ever pulls the line low or releases it.

Pins pass through a synchroniser before they are compared. The interrupt clears in either of two ways:
- every changed input returns to its captured level, with no action needed;
- a one-cycle read strobe loads the current synchronised levels into the captured register, which re-arms detection.

After reset the block waits for the synchroniser to fill. It then loads the pin levels it sees as the first reference. Changing a pin from output to input raises the interrupt immediately when the pin level does not match the captured value. This side effect is kept on purpose.

Top module: `ich_detect`

## Requirements
- R1: While rst_ni is low, port_val_o is all zeros and int_pd_o is 0 (line released).
- R2: After reset release with steady pins, port_val_o equals the synchronised pin levels no later than SYNC_STAGES+1 clock edges after release, and int_pd_o stays 0.
- R3: When a pin whose dir_i bit is 1 (input) changes so that it differs from its bit of port_val_o, int_pd_o becomes 1 after SYNC_STAGES clock edges.
- R4: If every changed input returns to its captured level, int_pd_o returns to 0 with no read strobe.
- R5: A rd_strobe_i pulse, once the reference is loaded, loads the synchronised pin levels into port_val_o at that clock edge. int_pd_o is then 0 if the pins are steady.
- R6: Pins whose dir_i bit is 0 (output) never cause int_pd_o to be 1, whatever their level.
- R7: Switching a dir_i bit from 0 to 1 on a pin whose synchronised level differs from its port_val_o bit sets int_pd_o to 1 in the same cycle, before the next clock edge.
- R8: port_val_o is unchanged on any edge without rd_strobe_i once the reference is loaded, even while pins change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous power-on reset |
| pins_i | input | WIDTH | Raw pin levels, asynchronous |
| dir_i | input | WIDTH | Per-pin direction, 1 = input, 0 = output |
| rd_strobe_i | input | 1 | One-cycle strobe marking a read of the input port register |
| port_val_o | output | WIDTH | Captured input port register value |
| int_pd_o | output | 1 | Interrupt pull-down enable, 1 = drive line low |

## Verification
The bench changes a pin and then restores it without a read. A design that latched the interrupt until a read would leave int_pd_o high here.

It toggles pins that are set as outputs. A design that left out the direction mask would raise a spurious interrupt.

It turns a mismatched output pin into an input. It checks that the interrupt appears before the next clock edge, which catches both a design that suppressed the side effect and one that registered the direction. It also checks that the captured value moves only on a read and that the first reference equals the pins seen at reset release.

// File: rtl/ich_pkg.sv
package ich_pkg;
  parameter int unsigned DEF_WIDTH  = 8;
  parameter int unsigned DEF_STAGES = 2;

  typedef enum logic [0:0] {
    ST_FILL  = 1'b0,
    ST_ARMED = 1'b1
  } ref_state_e;
endpackage

// File: rtl/ich_sync.sv
module ich_sync #(
  parameter int unsigned WIDTH  = ich_pkg::DEF_WIDTH,
  parameter int unsigned STAGES = ich_pkg::DEF_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/ich_ref_reg.sv
module ich_ref_reg #(
  parameter int unsigned WIDTH  = ich_pkg::DEF_WIDTH,
  parameter int unsigned STAGES = ich_pkg::DEF_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] sync_i,
  input  logic             rd_i,
  output logic [WIDTH-1:0] ref_o,
  output logic             armed_o
);
  import ich_pkg::*;

  localparam int unsigned CW = $clog2(STAGES + 1);

  ref_state_e       st_q;
  logic [CW-1:0]    cnt_q;
  logic [WIDTH-1:0] ref_q;

  // first load once the synchroniser holds real pin data
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_FILL;
      cnt_q <= '0;
      ref_q <= '0;
    end else begin
      unique case (st_q)
        ST_FILL: begin
          if (cnt_q == CW'(STAGES)) begin
            ref_q <= sync_i;
            st_q  <= ST_ARMED;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_ARMED: begin
          if (rd_i) ref_q <= sync_i;
        end
        default: st_q <= ST_FILL;
      endcase
    end
  end

  assign ref_o   = ref_q;
  assign armed_o = (st_q == ST_ARMED);
endmodule

// File: rtl/ich_cmp.sv
module ich_cmp #(
  parameter int unsigned WIDTH = ich_pkg::DEF_WIDTH
) (
  input  logic [WIDTH-1:0] sync_i,
  input  logic [WIDTH-1:0] ref_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic             armed_i,
  output logic             hit_o
);
  logic [WIDTH-1:0] diff;

  // output pins are masked; dir is not registered so a 0->1 flip acts at once
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign diff[b] = dir_i[b] & (sync_i[b] ^ ref_i[b]);
  end

  assign hit_o = armed_i & (|diff);
endmodule

// File: rtl/ich_detect.sv
module ich_detect #(
  parameter int unsigned WIDTH       = ich_pkg::DEF_WIDTH,
  parameter int unsigned SYNC_STAGES = ich_pkg::DEF_STAGES
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pins_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic             rd_strobe_i,
  output logic [WIDTH-1:0] port_val_o,
  output logic             int_pd_o
);
  logic [WIDTH-1:0] pin_sync;
  logic [WIDTH-1:0] ref_val;
  logic             armed;

  ich_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_i),
    .q_o   (pin_sync)
  );

  ich_ref_reg #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_ref (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sync_i (pin_sync),
    .rd_i   (rd_strobe_i),
    .ref_o  (ref_val),
    .armed_o(armed)
  );

  ich_cmp #(.WIDTH(WIDTH)) u_cmp (
    .sync_i (pin_sync),
    .ref_i  (ref_val),
    .dir_i  (dir_i),
    .armed_i(armed),
    .hit_o  (int_pd_o)
  );

  assign port_val_o = ref_val;
endmodule

// File: rtl/ich_detect_chk.sv
module ich_detect_chk #(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [WIDTH-1:0] dir_i,
  input logic             rd_strobe_i,
  input logic [WIDTH-1:0] port_val_o,
  input logic             int_pd_o,
  input logic [WIDTH-1:0] pin_sync
);
  int unsigned edges_q;
  logic        primed;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     edges_q <= 0;
    else if (edges_q <= SYNC_STAGES) edges_q <= edges_q + 1;
  end
  assign primed = (edges_q > SYNC_STAGES);

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      p_reset_idle_r1: assert (!int_pd_o && port_val_o == '0)
        else $error("reset state violated");
    end
  end

  p_first_ref_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edges_q == SYNC_STAGES) |=> (port_val_o == $past(pin_sync)));

  p_read_loads_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && rd_strobe_i) |=> (port_val_o == $past(pin_sync)));

  p_out_masked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_i == '0) |-> !int_pd_o);

  p_hold_no_read_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (primed && !rd_strobe_i) |=> $stable(port_val_o));
endmodule

bind ich_detect ich_detect_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .dir_i      (dir_i),
  .rd_strobe_i(rd_strobe_i),
  .port_val_o (port_val_o),
  .int_pd_o   (int_pd_o),
  .pin_sync   (pin_sync)
);

// File: tb/ich_detect_tb.sv
module ich_detect_tb;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] pins = 8'hA5;
  logic [W-1:0] dir = 8'hFF;
  logic         rd = 1'b0;
  logic [W-1:0] port_val;
  logic         int_pd;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  ich_detect #(.WIDTH(W), .SYNC_STAGES(2)) u_dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .pins_i     (pins),
    .dir_i      (dir),
    .rd_strobe_i(rd),
    .port_val_o (port_val),
    .int_pd_o   (int_pd)
  );

  // {rd, dir, pins, exp_val, exp_int, req}
  localparam int NV = 10;
  localparam logic [29:0] VEC [NV] = '{
    {1'b0, 8'hFF, 8'hA5, 8'hA5, 1'b0, 4'd2},  // R2 steady after reset
    {1'b0, 8'hFF, 8'hA4, 8'hA5, 1'b1, 4'd3},  // R3 input changes
    {1'b0, 8'hFF, 8'hA5, 8'hA5, 1'b0, 4'd4},  // R4 returns by itself
    {1'b0, 8'hFF, 8'h0F, 8'hA5, 1'b1, 4'd3},  // R3 several bits
    {1'b1, 8'hFF, 8'h0F, 8'h0F, 1'b0, 4'd5},  // R5 read re-arms
    {1'b0, 8'h0F, 8'h3F, 8'h0F, 1'b0, 4'd6},  // R6 output bits ignored
    {1'b0, 8'hFF, 8'h3F, 8'h0F, 1'b1, 4'd7},  // R7 output->input mismatch
    {1'b1, 8'hFF, 8'h3F, 8'h3F, 1'b0, 4'd5},  // R5 read clears
    {1'b0, 8'hFF, 8'h3E, 8'h3F, 1'b1, 4'd8},  // R8 value held while pin moves
    {1'b0, 8'hFF, 8'h3F, 8'h3F, 1'b0, 4'd4}   // R4
  };

  task automatic check(input int req, input logic [W-1:0] ev, input logic ei);
    total++;
    if (port_val !== ev || int_pd !== ei) begin
      bad++;
      $display("FAIL R%0d: port_val=%h int=%b expected port_val=%h int=%b",
               req, port_val, int_pd, ev, ei);
    end
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    #2000000;
    bad++;
    total++;
    $display("FAIL watchdog: run hung, expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    // R1 during reset
    wait_cycles(3);
    check(1, 8'h00, 1'b0);
    rst_n = 1'b1;
    wait_cycles(5);

    for (int v = 0; v < NV; v++) begin
      dir  = VEC[v][28:21];
      pins = VEC[v][20:13];
      rd   = VEC[v][29];
      @(negedge clk);
      rd   = 1'b0;
      wait_cycles(3);
      check(int'(VEC[v][3:0]), VEC[v][12:5], VEC[v][4]);
    end

    // R3 latency: pin change visible after exactly two edges
    pins = 8'h7F;
    wait_cycles(1);
    check(3, 8'h3F, 1'b0);
    wait_cycles(1);
    check(3, 8'h3F, 1'b1);
    pins = 8'h3F;
    wait_cycles(3);
    check(4, 8'h3F, 1'b0);

    // R7 same cycle: dir flip on mismatched output pin
    dir = 8'hFE;
    pins = 8'h3E;
    wait_cycles(3);
    check(6, 8'h3F, 1'b0);
    dir = 8'hFF;
    #2;
    check(7, 8'h3F, 1'b1);
    dir = 8'hFE;
    #2;
    check(6, 8'h3F, 1'b0);
    dir = 8'hFF;
    pins = 8'h3F;
    wait_cycles(3);

    // R1 mid-run reset, then R2 fresh reference
    pins = 8'hC3;
    rst_n = 1'b0;
    #2;
    check(1, 8'h00, 1'b0);
    wait_cycles(2);
    rst_n = 1'b1;
    wait_cycles(4);
    check(2, 8'hC3, 1'b0);

    // R8 reference untouched by pin activity without a read
    pins = 8'h00;
    wait_cycles(4);
    check(8, 8'hC3, 1'b1);
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
    check(5, 8'h00, 1'b0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule